// File: doc/BRIEF.md
# Host Bus Cycle Stretcher

This block sits between a fast soft CPU core and the slow bus of the host machine. For every CPU access it decides whether the access can finish at full core speed or must be stretched onto the host bus. When stretched, the access is aligned to one full high phase of the host's phase clock. The decision uses the address page, the access direction and a mirroring-enable input. Only the bus access cycle itself is lengthened. Every other cycle of an instruction runs at the fast clock, which is intended to be at most about 14.2 MHz.

There are three policies:

- **Fast.** No stall at all.
- **Held.** Waits for a host phase rising edge at which the host video chip reports the bus available.
- **Free.** Waits for a host phase rising edge and ignores bus availability.

The host phase clock and the bus-available line both pass through a two-flop synchroniser. Bus availability is looked at only at the rising edge that would launch the access. Once a host cycle has begun, it runs to the end of the phase.

The interface is plain control, with no data stream. The CPU raises `acc_start` for one cycle with a valid address. If `cpu_stall` is high in that same cycle, the CPU must hold its state until `cpu_stall` falls.

Top module: `host_stretch`

## Requirements
- R1: While reset is asserted and after its release with no access, `cpu_stall`, `host_cyc`, `host_we` and `host_exp` are all 0.
- R2: Pages 0xD0–0xD7 and 0xDC–0xDD (video, sound and the two timer chips), read or write, use the held policy. The host cycle starts only at a host phase rising edge at which `host_ba` is 1.
- R3: Pages 0xDE–0xDF (expansion selects) use the free policy. `host_ba` is ignored, and `host_exp` is 1 for the whole host cycle.
- R4: Pages 0xD8–0xDB (memory mapped into the I/O area) are fast for reads and writes. `cpu_stall` and `host_cyc` stay 0.
- R5: Reads anywhere outside pages 0xD0–0xDF are fast.
- R6: Writes outside pages 0xD0–0xDF use the held policy when `mirror_en` is 1 in the start cycle, and are fast when it is 0.
- R7: Let edge r be the first clock edge that samples `host_phi2` high. That rising edge can launch a pending access only if r+2 is later than the start edge. If it does, `host_cyc` rises after edge r+2 and stays high for as many clock edges as `host_phi2` was sampled high.
- R8: For held accesses, only the `host_ba` value sampled at edge r matters. A later change of `host_ba` does not shorten or end the host cycle.
- R9: `cpu_stall` is 1 in the start cycle of a stretched access, combinationally from `acc_start`. It stays 1 until the clock edge at which `host_cyc` falls, and falls at that same edge.
- R10: An `acc_start` strobe while a stretched access is pending or running is ignored. Timing, direction and select of the running access are unchanged.
- R11: `host_we` is 1 exactly during `host_cyc` of a write access (`cpu_rw` = 0). `host_exp` is 1 only during `host_cyc` of an expansion access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU access address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| acc_start | input | 1 | One-cycle access start strobe |
| mirror_en | input | 1 | Write mirroring to host memory enabled for this access |
| host_phi2 | input | 1 | Host phase clock, asynchronous |
| host_ba | input | 1 | Host video chip bus-available, asynchronous |
| cpu_stall | output | 1 | Hold the CPU in its current cycle |
| host_cyc | output | 1 | Host bus cycle in progress |
| host_we | output | 1 | Host bus write strobe |
| host_exp | output | 1 | Expansion select strobe |

## Verification
A wrong policy latch or a bad page decode shows at the ports within one cycle of the start strobe. The symptoms are a stall on a fast access, or a missing stall on a slow one. A fault in the synchroniser, the edge detector or the wait state moves the rising or falling edge of `host_cyc` against the host phase. The bench predicts those edges to the exact clock edge, so the fault shows within one host period. A wrongly sampled bus-available shows as a host cycle launched one period early or late. A strobe that is not ignored shows as a changed `host_we` or `host_exp` in the running cycle.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    POL_FAST = 2'd0,
    POL_HELD = 2'd1,
    POL_FREE = 2'd2
  } policy_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CYCLE = 2'd2
  } stretch_state_t;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbs_decode.sv
module hbs_decode
  import hbs_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] CHIPA_LO  = 8'hD0,
  parameter logic [7:0] CHIPA_HI  = 8'hD7,
  parameter logic [7:0] LOCAL_HI  = 8'hDB,
  parameter logic [7:0] CHIPB_HI  = 8'hDD,
  parameter logic [7:0] EXP_HI    = 8'hDF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              mirror_en,
  output policy_t           pol,
  output logic              is_exp
);
  localparam int PAGE_W = 8;

  logic [PAGE_W-1:0] page;
  logic in_chip, in_local, in_exp, in_io;

  assign page     = addr[ADDR_W-1 -: PAGE_W];
  assign in_io    = (page >= CHIPA_LO) && (page <= EXP_HI);
  assign in_chip  = ((page >= CHIPA_LO) && (page <= CHIPA_HI)) ||
                    ((page >  LOCAL_HI) && (page <= CHIPB_HI));
  assign in_local = (page > CHIPA_HI) && (page <= LOCAL_HI);
  assign in_exp   = (page > CHIPB_HI) && (page <= EXP_HI);

  always_comb begin
    pol = POL_FAST;
    if (in_chip)                       pol = POL_HELD;
    else if (in_exp)                   pol = POL_FREE;
    else if (in_local)                 pol = POL_FAST;
    else if (!in_io && !rw && mirror_en) pol = POL_HELD;
  end

  assign is_exp = in_exp;
endmodule

// File: rtl/host_stretch.sv
module host_stretch
  import hbs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              acc_start,
  input  logic              mirror_en,
  input  logic              host_phi2,
  input  logic              host_ba,
  output logic              cpu_stall,
  output logic              host_cyc,
  output logic              host_we,
  output logic              host_exp
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              phi_s, ba_s, phi_q;
  logic              phi_rise, phi_fall;
  policy_t           pol;
  logic              dec_exp, slow_start;
  stretch_state_t    state;
  logic              lat_we, lat_exp, lat_ba;

  hbs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({host_ba, host_phi2}),
    .q     (sync_q)
  );

  assign phi_s = sync_q[0];
  assign ba_s  = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phi_q <= 1'b0;
    else        phi_q <= phi_s;
  end

  assign phi_rise = phi_s & ~phi_q;
  assign phi_fall = ~phi_s & phi_q;

  hbs_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (cpu_addr),
    .rw        (cpu_rw),
    .mirror_en (mirror_en),
    .pol       (pol),
    .is_exp    (dec_exp)
  );

  assign slow_start = acc_start && (pol != POL_FAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lat_we  <= 1'b0;
      lat_exp <= 1'b0;
      lat_ba  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (slow_start) begin
          state   <= ST_WAIT;
          lat_we  <= ~cpu_rw;
          lat_exp <= dec_exp;
          lat_ba  <= (pol == POL_HELD);
        end
        ST_WAIT: if (phi_rise && (ba_s || !lat_ba)) state <= ST_CYCLE;
        ST_CYCLE: if (phi_fall) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_cyc  = (state == ST_CYCLE);
  assign host_we   = host_cyc & lat_we;
  assign host_exp  = host_cyc & lat_exp;
  assign cpu_stall = (state != ST_IDLE) || slow_start;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic host_phi2,
  input logic host_ba,
  input logic cpu_stall,
  input logic host_cyc,
  input logic host_we,
  input logic host_exp
);
  assert_cyc_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_cyc |-> cpu_stall);

  assert_stall_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_cyc) |-> (!cpu_stall || acc_start));

  assert_we_inside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> host_cyc);

  assert_exp_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_exp |-> host_cyc);

  assert_launch_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_cyc) |-> $past(host_phi2, 3));

  assert_end_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_cyc) |-> !$past(host_phi2, 3));

  assert_ba_at_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_cyc) && !host_exp) |-> $past(host_ba, 3));

  assert_strobes_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cyc && $past(host_cyc)) |-> ($stable(host_we) && $stable(host_exp)));
endmodule

bind host_stretch hbs_checker u_hbs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_start (acc_start),
  .host_phi2 (host_phi2),
  .host_ba   (host_ba),
  .cpu_stall (cpu_stall),
  .host_cyc  (host_cyc),
  .host_we   (host_we),
  .host_exp  (host_exp)
);

// File: tb/test_host_stretch.sv
module test_host_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int PER  = 14;
  localparam int HALF = 7;
  localparam int QOFF = 3;
  localparam int BA_N = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic        acc_start = 1'b0;
  logic        mirror_en = 1'b0;
  logic        host_phi2 = 1'b0;
  logic        host_ba = 1'b1;
  logic        cpu_stall, host_cyc, host_we, host_exp;

  int   compared = 0;
  int   mismatched = 0;
  int   cyc = 0;
  logic ba_tab [BA_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_stretch i_host_stretch (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .acc_start(acc_start), .mirror_en(mirror_en), .host_phi2(host_phi2),
    .host_ba(host_ba), .cpu_stall(cpu_stall), .host_cyc(host_cyc),
    .host_we(host_we), .host_exp(host_exp)
  );

  function automatic logic phi_at(int n);
    return (n % PER) >= HALF;
  endfunction

  function automatic int ba_idx(int n);
    return ((n + QOFF) / HALF) % BA_N;
  endfunction

  function automatic logic ba_at(int n);
    return ba_tab[ba_idx(n)];
  endfunction

  // 0 fast, 1 held, 2 free
  function automatic int pol_of(logic [15:0] a, logic rw, logic mir);
    logic [7:0] p = a[15:8];
    if ((p >= 8'hD0 && p <= 8'hD7) || (p >= 8'hDC && p <= 8'hDD)) return 1;
    if (p >= 8'hDE && p <= 8'hDF) return 2;
    if (p >= 8'hD8 && p <= 8'hDB) return 0;
    if (!rw && mir) return 1;
    return 0;
  endfunction

  function automatic string tag_of(logic [15:0] a, logic rw);
    logic [7:0] p = a[15:8];
    if ((p >= 8'hD0 && p <= 8'hD7) || (p >= 8'hDC && p <= 8'hDD)) return "R2";
    if (p >= 8'hDE && p <= 8'hDF) return "R3";
    if (p >= 8'hD8 && p <= 8'hDB) return "R4";
    if (rw) return "R5";
    return "R6";
  endfunction

  // edge after which host_cyc is expected high
  function automatic int exp_begin(int t, bit honour);
    for (int r = t - 2; r < t + 4000; r++) begin
      if ((r % PER) == HALF && (r + 2) > t && (!honour || ba_at(r))) return r + 2;
    end
    return t + 4000;
  endfunction

  task automatic chk(logic got, logic exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", what, cyc, got, exp);
    end
  endtask

  task automatic step(logic st, logic [15:0] a, logic rw, logic mir);
    @(negedge clk);
    host_phi2 = phi_at(cyc + 1);
    host_ba   = ba_at(cyc + 1);
    acc_start = st; cpu_addr = a; cpu_rw = rw; mirror_en = mir;
    @(posedge clk); cyc++; #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b1, 1'b0);
  endtask

  task automatic do_access(logic [15:0] a, logic rw, logic mir, bit intrude);
    int    p = pol_of(a, rw, mir);
    string tg = tag_of(a, rw);
    string ex = intrude ? " R10" : "";
    int    t, b, e;
    bit    hc;
    @(negedge clk);
    host_phi2 = phi_at(cyc + 1);
    host_ba   = ba_at(cyc + 1);
    acc_start = 1'b1; cpu_addr = a; cpu_rw = rw; mirror_en = mir;
    #1;
    chk(cpu_stall, p != 0, {tg, " R9 stall in start cycle"});
    @(posedge clk); cyc++; t = cyc; #1;
    if (p == 0) begin
      chk(cpu_stall, 1'b0, {tg, " fast access no stall"});
      chk(host_cyc, 1'b0, {tg, " fast access no host cycle"});
      return;
    end
    b = exp_begin(t, p == 1);
    e = b + HALF;
    forever begin
      hc = (cyc >= b) && (cyc < e);
      chk(host_cyc, hc, {tg, " R7 R8 host cycle window", ex});
      chk(cpu_stall, cyc < e, {tg, " R9 stall span", ex});
      chk(host_we, hc && !rw, {tg, " R11 write strobe", ex});
      chk(host_exp, hc && (p == 2), {tg, " R11 expansion select", ex});
      if (cyc >= e) break;
      if (intrude && cyc == t) step(1'b1, 16'hDE40, ~rw, 1'b0);
      else                     step(1'b0, a, rw, mir);
    end
  endtask

  function automatic logic [15:0] rand_addr(int sel);
    case (sel)
      0: return 16'hD000 + 16'($urandom % 16'h0800);
      1: return 16'hDC00 + 16'($urandom % 16'h0200);
      2: return 16'hDE00 + 16'($urandom % 16'h0200);
      3: return 16'hD800 + 16'($urandom % 16'h0400);
      4: return 16'($urandom % 32'hD000);
      default: return 16'hE000 + 16'($urandom % 16'h2000);
    endcase
  endfunction

  // steer bus-available for the next launching edge low, following one high
  task automatic block_next_ba();
    for (int r = cyc + 1; r < cyc + 3 * PER; r++) begin
      if ((r % PER) == HALF && (r + 2) > cyc + 1) begin
        ba_tab[ba_idx(r)] = 1'b0;
        ba_tab[ba_idx(r + PER)] = 1'b1;
        break;
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < BA_N; i++) ba_tab[i] = ($urandom % 4) != 0;

    idle(4);
    chk(cpu_stall, 1'b0, "R1 stall in reset");
    chk(host_cyc, 1'b0, "R1 host cycle in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2 * PER);
    chk(cpu_stall, 1'b0, "R1 stall after reset");
    chk(host_cyc, 1'b0, "R1 host cycle after reset");
    chk(host_we, 1'b0, "R1 write strobe after reset");
    chk(host_exp, 1'b0, "R1 expansion select after reset");

    // directed: each fast class
    do_access(16'hD9A0, 1'b0, 1'b1, 1'b0);   // R4 write
    do_access(16'hDB00, 1'b1, 1'b0, 1'b0);   // R4 read
    do_access(16'h1234, 1'b1, 1'b1, 1'b0);   // R5
    do_access(16'h0400, 1'b0, 1'b0, 1'b0);   // R6 unmirrored write
    idle(1);
    // directed: mirrored write, chip write, expansion read
    do_access(16'h0400, 1'b0, 1'b1, 1'b0);   // R6 mirrored
    do_access(16'hD020, 1'b0, 1'b0, 1'b0);   // R2
    do_access(16'hDF00, 1'b1, 1'b0, 1'b0);   // R3

    // directed: start exactly on the edge a rise would launch (R7)
    while (((cyc + 1) % PER) != ((HALF + 2) % PER)) idle(1);
    do_access(16'hDE08, 1'b1, 1'b0, 1'b0);

    // directed: bus not available at the next launch (R2 waits, R3 ignores)
    idle(2); block_next_ba();
    do_access(16'hD418, 1'b0, 1'b0, 1'b0);
    idle(2); block_next_ba();
    do_access(16'hDE00, 1'b0, 1'b0, 1'b0);

    // directed: strobe while busy is ignored (R10)
    idle(1);
    do_access(16'hDC0D, 1'b0, 1'b0, 1'b1);
    idle(1);
    do_access(16'h8000, 1'b0, 1'b1, 1'b1);

    // constrained random
    for (int k = 0; k < 160; k++) begin
      logic [15:0] a = rand_addr(int'($urandom % 6));
      idle(int'($urandom % 3));
      do_access(a, 1'($urandom), 1'($urandom), ($urandom % 8) == 0);
    end

    idle(PER);
    chk(cpu_stall, 1'b0, "R1 stall when quiet at end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule